// File: doc/BRIEF.md
# Time-Multiplexed Delay-Loop Reservoir Engine

This block turns a stream of scalar samples into a vector of reservoir node states. It has a single shared nonlinearity instead of an array of physical nodes. One sample is held for a whole loop period of `NODES` slots. In every slot the held sample is multiplied by a per-slot sign mask. That masked value is mixed with the state the same slot produced one period earlier, using two scalar gains. The sum passes through the function a/(1+a²), and the result is written back into a circular state memory.

Samples arrive on a valid/ready port. A sample is taken only when no period is in progress. If no sample is offered, the engine simply waits. Node states leave on a valid/ready stream in slot order, and a last flag marks the final slot.

The output follows standard back-pressure rules. The engine never drops or reorders a state. While `out_valid` is high and `out_ready` is low, the engine freezes all output fields and its own progress. The mask and the two gains are written through a plain parameter port, and those writes take effect only between periods. A synchronous clear empties the state memory. All values are signed Q4.12.

Top module: `dfr_engine`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. Every mask entry is +1, both gains are 0 and every stored node state is 0.
- R2: `in_ready` is 1 exactly when no period is in progress, and a transfer happens when `in_valid` and `in_ready` are both 1 at a clock edge. With no sample offered, the engine produces no output and keeps `in_ready` at 1.
- R3: The state of slot n is f(sat((p·j + q·xprev) >>> 12)). Here p·j and q·xprev are full signed products, the shift is arithmetic, and sat clamps to [-32768, 32767] instead of wrapping.
- R4: f(a) = (a·4096) / (4096 + ((a·a) >>> 12)), using signed integer division that truncates toward zero. Its magnitude never exceeds 2048 (0.5).
- R5: The value injected in slot n is j = +x when mask bit n is 1 and j = -x when it is 0, where x is the held sample. Negating -32768 saturates to 32767.
- R6: Each accepted sample yields exactly `NODES` outputs, with `out_idx` running 0, 1, … `NODES`-1. `out_last` is 1 only when `out_idx` is `NODES`-1.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data`, `out_idx` and `out_last` hold their values into the next cycle.
- R8: The parameter port writes only when `prm_we` is 1 and no period is in progress. With `prm_sel` = 0, it writes mask entry `prm_addr` from `prm_data[0]`. With `prm_sel` = 1, it writes gain p from `prm_data`. With `prm_sel` = 2, it writes gain q from `prm_data`. `prm_sel` = 3 writes nothing. Writes made while a period is in progress have no effect.
- R9: `clr` high at a clock edge zeroes every stored node state. A clear takes priority over a write-back in the same cycle.
- R10: xprev for slot n is the state that slot n produced in the previous period, or 0 after reset or clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Zero the node state memory |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Engine idle, sample can be taken |
| in_data | input | 16 | Sample, Q4.12 |
| prm_we | input | 1 | Parameter write strobe |
| prm_sel | input | 2 | 0 mask entry, 1 gain p, 2 gain q |
| prm_addr | input | $clog2(NODES) | Mask entry index |
| prm_data | input | 16 | Gain value (Q4.12) or mask bit in bit 0 |
| out_valid | output | 1 | Node state available |
| out_ready | input | 1 | Consumer accepts node state |
| out_data | output | 16 | Node state, Q4.12 |
| out_idx | output | $clog2(NODES) | Slot index of the state |
| out_last | output | 1 | Final slot of the period |

## Verification
Back-pressure combined with the feedback path is the hardest situation to reach from the ports. A stalled slot must leave both its output and the stored state of later slots untouched, and the next period must still read the correct earlier values. To get there, the bench drives `out_ready` with an irregular pattern across several whole periods. It checks every emitted state against a model that carries the node memory from one period to the next. It also writes the gains in the middle of a period and then checks that the following period still uses the old gains.

// File: rtl/dfr_pkg.sv
package dfr_pkg;
  localparam int DW   = 16;
  localparam int FRAC = 12;

  typedef logic signed [DW-1:0] q_t;

  // clamp a wide signed value to the Q4.12 range
  function automatic q_t sat_q(input logic signed [40:0] v);
    if (v > 41'sd32767)       return q_t'(16'sh7fff);
    else if (v < -41'sd32768) return q_t'(16'sh8000);
    else                      return q_t'(v[DW-1:0]);
  endfunction

  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_P    = 2'd1,
    SEL_Q    = 2'd2,
    SEL_NONE = 2'd3
  } prm_sel_e;
endpackage

// File: rtl/dfr_params.sv
module dfr_params
  import dfr_pkg::*;
#(
  parameter int NODES = 32,
  localparam int IW = $clog2(NODES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic [IW-1:0] addr,
  input  q_t            data,
  output logic [NODES-1:0] mask,
  output q_t            gain_p,
  output q_t            gain_q
);
  logic wr_ok;
  assign wr_ok = we && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gain_p <= '0;
      gain_q <= '0;
    end else if (wr_ok) begin
      if (prm_sel_e'(sel) == SEL_P) gain_p <= data;
      if (prm_sel_e'(sel) == SEL_Q) gain_q <= data;
    end
  end

  for (genvar n = 0; n < NODES; n++) begin : g_mask
    always_ff @(posedge clk) begin
      if (!rst_n) mask[n] <= 1'b1;
      else if (wr_ok && prm_sel_e'(sel) == SEL_MASK && addr == IW'(n))
        mask[n] <= data[0];
    end
  end

  AST_PRM_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && we) |=> ($stable(gain_p) && $stable(gain_q) && $stable(mask))); // R8
endmodule

// File: rtl/dfr_nonlin.sv
module dfr_nonlin
  import dfr_pkg::*;
(
  input  q_t a,
  output q_t y
);
  logic signed [31:0] a_w, sq, den, num, quo;

  always_comb begin
    a_w = 32'(a);
    sq  = (a_w * a_w) >>> FRAC;
    den = (32'sd1 <<< FRAC) + sq;
    num = a_w <<< FRAC;
    quo = num / den;
    y   = q_t'(quo[DW-1:0]);
  end

  always_comb begin
    AST_NL_BOUND: assert (quo <= 32'sd2048 && quo >= -32'sd2048); // R4
  end
endmodule

// File: rtl/dfr_mix.sv
module dfr_mix
  import dfr_pkg::*;
(
  input  q_t   sample,
  input  logic mask_bit,
  input  q_t   gain_p,
  input  q_t   gain_q,
  input  q_t   prev,
  output q_t   pre
);
  logic signed [16:0] neg;
  q_t                 inj;
  logic signed [40:0] acc;

  always_comb begin
    neg = -17'(sample);
    inj = mask_bit ? sample : sat_q(41'(neg));
    acc = (41'(gain_p) * 41'(inj) + 41'(gain_q) * 41'(prev)) >>> FRAC;
    pre = sat_q(acc);
  end
endmodule

// File: rtl/dfr_engine.sv
module dfr_engine
  import dfr_pkg::*;
#(
  parameter int NODES = 32,
  localparam int IW = $clog2(NODES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [15:0]   in_data,
  input  logic          prm_we,
  input  logic [1:0]    prm_sel,
  input  logic [IW-1:0] prm_addr,
  input  logic [15:0]   prm_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [15:0]   out_data,
  output logic [IW-1:0] out_idx,
  output logic          out_last
);
  logic             running, advance, slot_end;
  logic [IW-1:0]    slot;
  q_t               held, gp, gq, pre, node_new;
  logic [NODES-1:0] mask;
  q_t               loopmem [NODES];

  assign in_ready = !running;
  assign advance  = running && (!out_valid || out_ready);
  assign slot_end = (slot == IW'(NODES - 1));

  dfr_params #(.NODES(NODES)) u_prm (
    .clk(clk), .rst_n(rst_n), .busy(running), .we(prm_we), .sel(prm_sel),
    .addr(prm_addr), .data(q_t'(prm_data)), .mask(mask), .gain_p(gp), .gain_q(gq)
  );

  dfr_mix u_mix (
    .sample(held), .mask_bit(mask[slot]), .gain_p(gp), .gain_q(gq),
    .prev(loopmem[slot]), .pre(pre)
  );

  dfr_nonlin u_nl (.a(pre), .y(node_new));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running   <= 1'b0;
      slot      <= '0;
      held      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_idx   <= '0;
      out_last  <= 1'b0;
    end else begin
      if (in_valid && in_ready) begin
        held    <= q_t'(in_data);
        running <= 1'b1;
        slot    <= '0;
      end else if (advance) begin
        slot <= slot_end ? '0 : slot + 1'b1;
        if (slot_end) running <= 1'b0;
      end
      if (advance) begin
        out_valid <= 1'b1;
        out_data  <= node_new;
        out_idx   <= slot;
        out_last  <= slot_end;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  for (genvar n = 0; n < NODES; n++) begin : g_mem
    always_ff @(posedge clk) begin
      if (!rst_n || clr)                   loopmem[n] <= '0;
      else if (advance && slot == IW'(n))  loopmem[n] <= node_new;
    end
  end

  AST_TAKE_AT_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (slot == '0)); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_idx) && $stable(out_last))); // R7
  AST_LAST_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_last == (out_idx == IW'(NODES - 1)))); // R6
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=>
      (out_valid && out_idx == $past(out_idx) + 1'b1)); // R6
  AST_NO_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !(advance && slot_end)) |=> !in_ready); // R2
endmodule

// File: tb/sim_dfr_engine.sv
module sim_dfr_engine;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 32;
  localparam int IW = $clog2(N);
  localparam int ROWS = 6;
  // each row: {sample, gain p, gain q}
  localparam logic [47:0] VEC [ROWS] = '{
    {16'sh1000, 16'sh1000, 16'sh0000},
    {16'sh0800, 16'sh1800, 16'sh0c00},
    {16'shf000, 16'sh2000, 16'shf400},
    {16'sh7fff, 16'sh0400, 16'sh1000},
    {16'sh8000, 16'sh3000, 16'sh0800},
    {16'sh0123, 16'shf800, 16'sh1f00}
  };

  logic clk = 0, rst_n = 0, clr = 0;
  logic in_valid = 0, prm_we = 0, out_ready = 1;
  logic [15:0] in_data = 0, prm_data = 0;
  logic [1:0] prm_sel = 0;
  logic [IW-1:0] prm_addr = 0;
  logic in_ready, out_valid, out_last;
  logic [15:0] out_data;
  logic [IW-1:0] out_idx;

  int checks = 0, errors = 0, cyc = 0, rx_cnt = 0;
  logic bp = 0;
  logic [N-1:0] m_mask;
  logic signed [15:0] m_p, m_q;
  logic signed [15:0] m_mem [N];
  logic signed [15:0] exp_v [N];
  logic prev_stall = 0;
  logic [15:0] prev_data = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dfr_engine #(.NODES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .prm_we(prm_we), .prm_sel(prm_sel), .prm_addr(prm_addr),
    .prm_data(prm_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_idx(out_idx), .out_last(out_last)
  );

  function automatic logic signed [15:0] clamp(input longint v);
    if (v > 32767) return 16'sh7fff;
    if (v < -32768) return 16'sh8000;
    return 16'(v);
  endfunction

  function automatic logic signed [15:0] fnl(input logic signed [15:0] a);
    int av, d;
    av = int'(a);
    d = 4096 + ((av * av) >>> 12);
    return 16'((av * 4096) / d);
  endfunction

  task automatic check(input string req, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    out_ready <= bp ? (cyc[0] ^ cyc[2]) : 1'b1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      finish_run();
    end
  end

  // output monitor, samples between edges
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        check("R7 valid held", longint'(out_valid), 1);
        check("R7 data held", longint'(out_data), longint'(prev_data));
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (out_valid && out_ready) begin
        check("R6 slot order", longint'(out_idx), longint'(rx_cnt));
        check("R6 last flag", longint'(out_last), longint'(rx_cnt == N-1));
        check("R3 node state", longint'($signed(out_data)), longint'(exp_v[rx_cnt % N]));
        rx_cnt++;
      end
    end
  end

  task automatic wr(input logic [1:0] s, input int a, input logic [15:0] d);
    @(negedge clk);
    prm_we = 1; prm_sel = s; prm_addr = IW'(a); prm_data = d;
    @(negedge clk);
    prm_we = 0;
  endtask

  task automatic model_wr(input logic [1:0] s, input int a, input logic [15:0] d);
    wr(s, a, d);
    if (s == 0) m_mask[a] = d[0];
    if (s == 1) m_p = d;
    if (s == 2) m_q = d;
  endtask

  // expected states from R3/R4/R5/R10, then hand the sample over
  task automatic send(input logic signed [15:0] x);
    logic acc;
    for (int n = 0; n < N; n++) begin
      logic signed [15:0] j;
      j = m_mask[n] ? x : clamp(-longint'(x));
      exp_v[n] = fnl(clamp((longint'(m_p) * j + longint'(m_q) * m_mem[n]) >>> 12));
      m_mem[n] = exp_v[n];
    end
    rx_cnt = 0;
    @(negedge clk);
    in_valid = 1; in_data = x;
    acc = 0;
    while (!acc) begin
      acc = in_ready;
      @(negedge clk);
    end
    in_valid = 0;
  endtask

  task automatic wait_period();
    while (rx_cnt < N) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    m_mask = '1; m_p = 0; m_q = 0;
    for (int n = 0; n < N; n++) m_mem[n] = 0;
    for (int n = 0; n < N; n++) exp_v[n] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check("R1 out_valid", longint'(out_valid), 0);
    check("R1 in_ready", longint'(in_ready), 1);
    // R1: zero gains give all-zero states
    send(16'sh1000); wait_period();

    // R5: mask pattern, bit = 1 means +1
    for (int n = 0; n < N; n++) model_wr(2'd0, n, {15'd0, 1'(((n * 5 + 1) % 3) != 0)});
    // R8: selector 3 writes nothing
    wr(2'd3, 0, 16'sh7fff);

    // table walk: R3, R4, R5, R10 carried across periods
    for (int r = 0; r < ROWS; r++) begin
      model_wr(2'd1, 0, VEC[r][31:16]);
      model_wr(2'd2, 0, VEC[r][15:0]);
      bp = (r >= 3);
      send(VEC[r][47:32]);
      wait_period();
    end
    bp = 0;

    // R2: no sample offered, engine waits
    rx_cnt = 0;
    repeat (10) @(negedge clk);
    check("R2 no output when idle", longint'(rx_cnt), 0);
    check("R2 ready while idle", longint'(in_ready), 1);
    check("R2 valid low while idle", longint'(out_valid), 0);

    // R8: write during a period is ignored
    send(16'sh0400);
    check("R2 busy not ready", longint'(in_ready), 0);
    wr(2'd1, 0, 16'sh7fff);
    wr(2'd0, 0, {15'd0, ~m_mask[0]});
    wait_period();
    send(16'sh0400); wait_period();

    // R9: clear zeroes the loop memory, seen through R10 feedback
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    for (int n = 0; n < N; n++) m_mem[n] = 0;
    model_wr(2'd1, 0, 16'sh0000);
    model_wr(2'd2, 0, 16'sh1000);
    send(16'sh1000); wait_period();

    // R3/R5 saturation: extreme gain and most negative sample
    model_wr(2'd1, 0, 16'sh7fff);
    model_wr(2'd2, 0, 16'sh7fff);
    bp = 1;
    send(16'sh8000); wait_period();
    send(16'sh7fff); wait_period();
    bp = 0;
    finish_run();
  end
endmodule